// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block arbitrates interrupt requests for a small 8-bit processor core. Nine event sources each own a pending flag: a periodic timer tick (one every 1.024 ms), a hub status change, an edge on any general-purpose pin, serial-bus (I2C) activity, and five USB endpoint events. The event producers and the tick generation are outside the block. Each flag is set by a one-cycle strobe on its event input. It stays set until that source is serviced or the block is reset.

Two bus-visible registers hold the per-source enables, and one global enable bit gates every request. The core signals each instruction boundary with a strobe. At a boundary where the global enable is set and at least one enabled source is pending, the controller takes the highest-priority request. In that same edge it clears the global enable and the winner's pending flag. During the following cycle it raises a one-cycle call request together with the vector address the core must call. An enable-interrupts command or a return-from-interrupt command sets the global enable again, which allows nested interrupts.

All pins are plain control and status signals. No stream moves through the block, so there is no valid/ready handshake and no back-pressure. The core maps `gie_o` into bit 2 of its own processor status register.

Top module: `intc_vectored`

## Requirements
- R1: After reset, both enable registers read 0, the global enable is 0, and neither `call_o` nor `req_o` is asserted.
- R2: The core-source enable register sits at address 0x20 and uses these bits: bit 1 = timer (source 0), bit 3 = hub change (source 1), bit 5 = pin edge (source 2), bit 6 = I2C (source 3). The endpoint enable register sits at address 0x21, and its bits 0..4 enable endpoints A0, A1, A2, B0, B1 (sources 4..8). All other bits of both registers, and all other addresses, read as 0 and ignore writes.
- R3: A strobe on `evt_i[k]` sets pending flag k. The flag stays set, even while its enable is 0, until source k is serviced. A flag latched while disabled raises a request once it is enabled.
- R4: `req_o` is 1 exactly when the global enable is 1 and some pending source has its enable bit at 1.
- R5: A request is taken only at a clock edge where `instr_done_i` is 1. `call_o` is then high for exactly one cycle, the cycle after that edge.
- R6: When several requests compete, the source with the lowest index wins.
- R7: While `call_o` is high, `vec_o` equals `VEC_BASE + 2*k`, where k is the serviced source.
- R8: Taking a request clears the global enable and the serviced source's pending flag. Every other flag is left unchanged.
- R9: A pulse on `ei_i` or `reti_i` sets the global enable one edge later. If a request is taken in that same edge, the clear wins and the global enable ends at 0.
- R10: If an event strobe and the service clear hit the same pending flag in the same edge, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 9 | One-cycle event strobes, index = source number |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Register write address |
| wr_data_i | input | 8 | Register write data |
| rd_addr_i | input | 8 | Register read address |
| rd_data_o | output | 8 | Register read data (combinational) |
| instr_done_i | input | 1 | Instruction-boundary strobe from the core |
| ei_i | input | 1 | Enable-interrupts command |
| reti_i | input | 1 | Return-from-interrupt command |
| req_o | output | 1 | An enabled request is waiting and interrupts are on |
| call_o | output | 1 | One-cycle call request |
| vec_o | output | 8 | Vector address of the last serviced source |
| gie_o | output | 1 | Global interrupt enable state |

## Verification
Two pairs of functions can meet in one cycle. In the first, the service clear of a pending flag lands in the same edge as a fresh event strobe for that source. In the second, an enable-interrupts command arrives in the same edge as an acknowledge. The bench provokes each by raising both inputs in the same cycle as the boundary strobe. It judges the first by re-enabling and confirming that the same vector is called again. It judges the second by reading `gie_o` as 0 after that edge. Sweeps over every source, every source pair and all 512 enable masks cover priority and vector arithmetic.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int unsigned N_CORE = 4;
  localparam int unsigned N_EP   = 5;
  localparam int unsigned N_SRC  = N_CORE + N_EP;
  localparam int unsigned IDX_W  = $clog2(N_SRC);
  localparam int unsigned DATA_W = 8;

  typedef logic [N_SRC-1:0] src_vec_t;
  typedef logic [IDX_W-1:0] src_idx_t;

  // bit position of each core source's enable in the core enable register
  function automatic logic [2:0] core_bit(input int k);
    case (k)
      0:       core_bit = 3'd1;  // timer tick
      1:       core_bit = 3'd3;  // hub change
      2:       core_bit = 3'd5;  // pin edge
      default: core_bit = 3'd6;  // I2C
    endcase
  endfunction
endpackage

// File: rtl/intc_enable_regs.sv
module intc_enable_regs
  import intc_pkg::*;
#(
  parameter int unsigned AW = 8,
  parameter logic [AW-1:0] CORE_ADDR = 8'h20,
  parameter logic [AW-1:0] EP_ADDR   = 8'h21
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [AW-1:0]     wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output src_vec_t          en_o
);
  logic [N_CORE-1:0] core_en_q;
  logic [N_EP-1:0]   ep_en_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      core_en_q <= '0;
      ep_en_q   <= '0;
    end else if (wr_en) begin
      if (wr_addr == CORE_ADDR) begin
        for (int k = 0; k < int'(N_CORE); k++)
          core_en_q[k] <= wr_data[core_bit(k)];
      end
      if (wr_addr == EP_ADDR)
        ep_en_q <= wr_data[N_EP-1:0];
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == CORE_ADDR) begin
      for (int k = 0; k < int'(N_CORE); k++)
        rd_data[core_bit(k)] = core_en_q[k];
    end else if (rd_addr == EP_ADDR) begin
      rd_data[N_EP-1:0] = ep_en_q;
    end
  end

  assign en_o = {ep_en_q, core_en_q};
endmodule

// File: rtl/intc_pending.sv
module intc_pending #(
  parameter int unsigned N = 9
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] pend_o
);
  for (genvar g = 0; g < N; g++) begin : g_flag
    logic flag_q;
    always_ff @(posedge clk) begin
      if (!rst_n)         flag_q <= 1'b0;
      else if (set_i[g])  flag_q <= 1'b1;   // a new event beats the clear
      else if (clr_i[g])  flag_q <= 1'b0;
    end
    assign pend_o[g] = flag_q;
  end
endmodule

// File: rtl/intc_prio_pick.sv
module intc_prio_pick #(
  parameter int unsigned N  = 9,
  parameter int unsigned IW = 4
) (
  input  logic [N-1:0]  req_i,
  output logic          any_o,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = int'(N) - 1; i >= 0; i--)
      if (req_i[i]) idx_o = IW'(i);
  end
  assign any_o = |req_i;
endmodule

// File: rtl/intc_vectored.sv
module intc_vectored
  import intc_pkg::*;
#(
  parameter int unsigned   AW        = 8,
  parameter logic [AW-1:0] CORE_ADDR = 8'h20,
  parameter logic [AW-1:0] EP_ADDR   = 8'h21,
  parameter int unsigned   VEC_W     = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h04
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  evt_i,
  input  logic              wr_en_i,
  input  logic [AW-1:0]     wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [AW-1:0]     rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              instr_done_i,
  input  logic              ei_i,
  input  logic              reti_i,
  output logic              req_o,
  output logic              call_o,
  output logic [VEC_W-1:0]  vec_o,
  output logic              gie_o
);
  src_vec_t   en, pend, clr;
  src_idx_t   win;
  logic       any;
  logic       gie_q, call_q, ack;
  logic [VEC_W-1:0] vec_q;

  intc_enable_regs #(.AW(AW), .CORE_ADDR(CORE_ADDR), .EP_ADDR(EP_ADDR)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .wr_addr(wr_addr_i),
    .wr_data(wr_data_i), .rd_addr(rd_addr_i), .rd_data(rd_data_o), .en_o(en)
  );

  intc_pending #(.N(N_SRC)) u_pend (
    .clk(clk), .rst_n(rst_n), .set_i(evt_i), .clr_i(clr), .pend_o(pend)
  );

  intc_prio_pick #(.N(N_SRC), .IW(IDX_W)) u_pick (
    .req_i(pend & en), .any_o(any), .idx_o(win)
  );

  assign ack = instr_done_i & gie_q & any;
  assign clr = ack ? (src_vec_t'(1) << win) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      gie_q  <= 1'b0;
      call_q <= 1'b0;
      vec_q  <= VEC_BASE;
    end else begin
      call_q <= ack;
      if (ack) begin
        gie_q <= 1'b0;
        vec_q <= VEC_BASE + VEC_W'({win, 1'b0});
      end else if (ei_i || reti_i) begin
        gie_q <= 1'b1;
      end
    end
  end

  assign req_o  = gie_q & any;
  assign call_o = call_q;
  assign vec_o  = vec_q;
  assign gie_o  = gie_q;
endmodule

// File: rtl/intc_vectored_chk.sv
module intc_vectored_chk #(
  parameter int unsigned   AW      = 8,
  parameter logic [AW-1:0] EP_ADDR = 8'h21,
  parameter int unsigned   VEC_W   = 8,
  parameter logic [VEC_W-1:0] VEC_BASE = 8'h04,
  parameter int unsigned   N       = 9
) (
  input logic             clk,
  input logic             rst_n,
  input logic             instr_done_i,
  input logic             ei_i,
  input logic             reti_i,
  input logic             req_o,
  input logic             call_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             gie_o,
  input logic [AW-1:0]    rd_addr_i,
  input logic [7:0]       rd_data_o
);
  a_r5_call_single: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |=> !call_o);

  a_r5_call_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(call_o) |-> $past(instr_done_i) && $past(gie_o));

  a_r8_call_clears_gie: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> !gie_o);

  a_r4_req_needs_gie: assert property (@(posedge clk) disable iff (!rst_n)
    req_o |-> gie_o);

  a_r9_enable_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    ((ei_i || reti_i) && !instr_done_i) |=> gie_o);

  a_r7_vec_in_table: assert property (@(posedge clk) disable iff (!rst_n)
    call_o |-> (vec_o >= VEC_BASE) && ((vec_o - VEC_BASE) <= VEC_W'(2*(N-1)))
               && !vec_o[0] == !VEC_BASE[0]);

  a_r2_ep_reserved: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_addr_i == EP_ADDR) |-> (rd_data_o[7:5] == 3'b000));
endmodule

bind intc_vectored intc_vectored_chk #(
  .AW(AW), .EP_ADDR(EP_ADDR), .VEC_W(VEC_W), .VEC_BASE(VEC_BASE), .N(intc_pkg::N_SRC)
) u_chk (
  .clk(clk), .rst_n(rst_n), .instr_done_i(instr_done_i), .ei_i(ei_i),
  .reti_i(reti_i), .req_o(req_o), .call_o(call_o), .vec_o(vec_o),
  .gie_o(gie_o), .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o)
);

// File: tb/intc_vectored_bench.sv
`timescale 1ns/1ps
module intc_vectored_bench;
  import intc_pkg::*;
  localparam logic [7:0] BASE = 8'h04;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N_SRC-1:0] evt = '0;
  logic wr_en = 1'b0;
  logic [7:0] wr_addr = '0, wr_data = '0, rd_addr = '0;
  logic [7:0] rd_data;
  logic instr_done = 1'b0, ei = 1'b0, reti = 1'b0;
  logic req, call, gie;
  logic [7:0] vec;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  intc_vectored u_intc_vectored (
    .clk(clk), .rst_n(rst_n), .evt_i(evt), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .instr_done_i(instr_done), .ei_i(ei), .reti_i(reti), .req_o(req),
    .call_o(call), .vec_o(vec), .gie_o(gie)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(); @(negedge clk); endtask

  task automatic reset();
    rst_n = 1'b0; cyc(); cyc(); rst_n = 1'b1; cyc();
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d; cyc(); wr_en = 1'b0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string tag);
    rd_addr = a; #1;
    chk(rd_data == exp, tag, rd_data, exp);
  endtask

  function automatic logic [7:0] core_val(input logic [3:0] m);
    return {1'b0, m[3], m[2], 1'b0, m[1], 1'b0, m[0], 1'b0};
  endfunction

  task automatic set_en(input logic [8:0] m);
    wr(8'h20, core_val(m[3:0]));
    wr(8'h21, {3'b000, m[8:4]});
  endtask

  task automatic fire(input logic [8:0] m); evt = m; cyc(); evt = '0; endtask
  task automatic do_ei(); ei = 1'b1; cyc(); ei = 1'b0; endtask
  task automatic do_reti(); reti = 1'b1; cyc(); reti = 1'b0; endtask
  task automatic boundary(); instr_done = 1'b1; cyc(); instr_done = 1'b0; endtask

  function automatic int lowest(input logic [8:0] m);
    for (int i = 0; i < 9; i++) if (m[i]) return i;
    return -1;
  endfunction

  // boundary and expect a call to source k
  task automatic expect_call(input int k, input string tag);
    boundary();
    chk(call == 1'b1, {tag, " call"}, call, 1);
    chk(vec == BASE + 8'(2*k), {tag, " vec"}, vec, BASE + 8'(2*k));
    chk(gie == 1'b0, {tag, " gie cleared"}, gie, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    reset();
    // R1 reset state
    chk(gie == 0, "R1 gie", gie, 0);
    chk(call == 0, "R1 call", call, 0);
    chk(req == 0, "R1 req", req, 0);
    rd_chk(8'h20, 8'h00, "R1 core reg");
    rd_chk(8'h21, 8'h00, "R1 ep reg");

    // R2 map, reserved bits and foreign addresses
    wr(8'h20, 8'hFF); rd_chk(8'h20, 8'h6A, "R2 core reserved");
    wr(8'h21, 8'hFF); rd_chk(8'h21, 8'h1F, "R2 ep reserved");
    wr(8'h22, 8'h00); rd_chk(8'h20, 8'h6A, "R2 other addr core");
    rd_chk(8'h21, 8'h1F, "R2 other addr ep");
    rd_chk(8'h22, 8'h00, "R2 other addr read");

    // R3/R4 disabled pending stays latched, fires once enabled
    reset();
    fire(9'h004); do_ei();
    chk(gie == 1, "R9 ei sets gie", gie, 1);
    chk(req == 0, "R4 disabled no req", req, 0);
    boundary();
    chk(call == 0, "R4 no call when disabled", call, 0);
    for (int i = 0; i < 20; i++) cyc();
    set_en(9'h1FF);
    chk(req == 1, "R3 latched fires later", req, 1);
    // R5 no call without boundary
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk(call == 0, "R5 waits for boundary", call, 0);
    end
    expect_call(2, "R5 R7");
    cyc();
    chk(call == 0, "R5 single pulse", call, 0);

    // R8 single-source sweep
    for (int k = 0; k < 9; k++) begin
      reset(); set_en(9'h1FF);
      fire(9'(1 << k)); do_ei();
      chk(req == 1, "R4 req", req, 1);
      expect_call(k, "R7 sweep");
      chk(req == 0, "R4 req off with gie 0", req, 0);
      do_ei();
      chk(req == 0, "R8 serviced flag cleared", req, 0);
    end

    // R6 pair sweep, R8 other flag kept, R9 reti
    for (int i = 0; i < 9; i++) begin
      for (int j = 0; j < 9; j++) begin
        reset(); set_en(9'h1FF);
        fire(9'((1 << i) | (1 << j))); do_ei();
        expect_call(i < j ? i : j, "R6 pair first");
        if (i != j) begin
          do_reti();
          chk(gie == 1, "R9 reti sets gie", gie, 1);
          chk(req == 1, "R8 other flag kept", req, 1);
          expect_call(i < j ? j : i, "R6 pair second");
        end
        do_ei();
        chk(req == 0, "R8 all serviced", req, 0);
      end
    end

    // R4/R6 enable mask sweep
    for (int m = 0; m < 512; m++) begin
      reset(); set_en(9'(m));
      fire(9'h1FF); do_ei();
      chk(req == (m != 0), "R4 mask req", req, (m != 0));
      boundary();
      if (m != 0) begin
        chk(call == 1 && vec == BASE + 8'(2*lowest(9'(m))), "R6 mask winner",
            vec, BASE + 8'(2*lowest(9'(m))));
      end else begin
        chk(call == 0 && gie == 1, "R4 mask none", call, 0);
      end
    end

    // R10 event and service clear in the same edge
    reset(); set_en(9'h1FF);
    fire(9'h004); do_ei();
    evt = 9'h004; instr_done = 1'b1; cyc(); evt = '0; instr_done = 1'b0;
    chk(call == 1 && vec == BASE + 8'd4, "R10 call", vec, BASE + 8'd4);
    do_ei();
    chk(req == 1, "R10 flag survives", req, 1);
    expect_call(2, "R10 recall");

    // R9 ei in the acknowledge edge loses
    reset(); set_en(9'h1FF);
    fire(9'h001); do_ei();
    ei = 1'b1; instr_done = 1'b1; cyc(); ei = 1'b0; instr_done = 1'b0;
    chk(call == 1, "R9 ack call", call, 1);
    chk(gie == 0, "R9 clear wins", gie, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule